// File: doc/BRIEF.md
# Trigger Window Hit Matcher

This block sits between one double-column readout path and the downstream FIFO. Each incoming word carries an 8-bit timestamp, counted in 25 ns ticks, and a pixel payload. The block holds these words in a small circular store. A mode bit selects one of two policies.

In streaming mode the store behaves as a plain FIFO and every word is forwarded. In trigger mode words are held, and a trigger pulse starts a scan of the store. The scan forwards only the words whose timestamps fall inside a window. The window opens a programmed latency before the trigger time and stays open for a programmed number of ticks. Words stay in the store after a scan, so a later trigger can select them again. A word leaves the store only when it grows too old.

Timestamps and the free-running time counter wrap modulo 256. All window and age arithmetic is done modulo 256.

Top module: `trig_hit_matcher`

## Requirements
- R1: With the active mode at 0 (streaming), every accepted word appears on the output once, with timestamp and payload unchanged, in arrival order.
- R2: With the active mode at 1 (trigger), a trigger pulse captures time T = ts_now_i. The block then emits, in arrival order, every stored word whose timestamp t satisfies ((t - (T - lat_i)) mod 256) <= unc_i. It emits no other word, and no word is emitted without a trigger.
- R3: Both window edges are inclusive. With T = 240, lat_i = 123 and unc_i = 6, timestamps 117 through 123 are selected, and 116 and 124 are not.
- R4: Window arithmetic wraps modulo 256. With T = 5, lat_i = 10 and unc_i = 7, timestamps 251, 0 and 2 are selected, and 250 and 3 are not. With unc_i = 0, exactly one timestamp value is selected.
- R5: A scan does not remove words from the store. A later trigger with the same window emits the same words again.
- R6: In trigger mode, outside a scan, the oldest word is dropped once (ts_now_i - t) mod 256 exceeds 240. A word with an age of exactly 240 is kept. A dropped word is never emitted.
- R7: The store holds 16 words. in_ready_o is low while it is full.
- R8: During a scan, in_ready_o is low and further trigger pulses are ignored.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_ts_o and out_data_o stay stable. No word is lost under backpressure.
- R10: mode_trig_i is taken into the active mode only while the store is empty. Words already stored are handled in the mode that was active when they were stored.
- R11: After reset, out_valid_o is low, in_ready_o is high and the active mode is streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_trig_i | input | 1 | Requested mode: 1 = trigger, 0 = streaming |
| lat_i | input | LAT_W (8) | Trigger latency in ticks |
| unc_i | input | UNC_W (3) | Window width in ticks |
| ts_now_i | input | 8 | Free-running timestamp counter |
| trig_i | input | 1 | Trigger pulse |
| in_valid_i | input | 1 | Input word valid |
| in_ts_i | input | 8 | Input word timestamp |
| in_data_i | input | PAY_W (16) | Input word payload |
| in_ready_o | output | 1 | Input word accepted |
| out_valid_o | output | 1 | Output word valid |
| out_ts_o | output | 8 | Output word timestamp |
| out_data_o | output | PAY_W (16) | Output word payload |
| out_ready_i | input | 1 | Downstream accepts the output word |

## Verification
The hardest case to reach is a second trigger that lands while a scan is still running. A scan that has no backpressure finishes within a few cycles. The bench therefore holds out_ready_i low so the scan stalls on its first selected word, and only then pulses the trigger again. The scoreboard must then see every selected word exactly once.

Age-based dropping at the exact 240/241 boundary is the other hard case. The bench reaches it by parking the time counter and writing timestamps at those precise distances behind it.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int TS_W = 8;

  function automatic logic [TS_W-1:0] ts_sub(input logic [TS_W-1:0] a,
                                             input logic [TS_W-1:0] b);
    return a - b;
  endfunction
endpackage

// File: rtl/thm_ring.sv
module thm_ring #(
  parameter int W     = 24,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_data_o,
  output logic [AW-1:0] head_ptr_o,
  output logic [CW-1:0] count_o,
  input  logic [AW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= wp + 1'b1;
      if (pop_i)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= push_data_i;
  end

  assign head_data_o = mem[rp];
  assign head_ptr_o  = rp;
  assign count_o     = cnt;
  assign rd_data_o   = mem[rd_idx_i];
endmodule

// File: rtl/thm_window.sv
module thm_window
  import thm_pkg::*;
#(
  parameter int UNC_W = 3
) (
  input  logic [TS_W-1:0]  ts_i,
  input  logic [TS_W-1:0]  start_i,
  input  logic [UNC_W-1:0] unc_i,
  output logic             hit_o
);
  logic [TS_W-1:0] off;
  assign off   = ts_sub(ts_i, start_i);
  assign hit_o = int'(off) <= int'(unc_i);
endmodule

// File: rtl/thm_scan.sv
module thm_scan #(
  parameter int AW   = 4,
  parameter int CW   = 5,
  parameter int TS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   head_ptr_i,
  input  logic [CW-1:0]   count_i,
  input  logic [TS_W-1:0] win_start_i,
  input  logic            adv_i,
  output logic            busy_o,
  output logic [AW-1:0]   idx_o,
  output logic [TS_W-1:0] win_start_o
);
  logic [CW-1:0] left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o      <= 1'b0;
      idx_o       <= '0;
      left        <= '0;
      win_start_o <= '0;
    end else if (!busy_o) begin
      if (start_i && count_i != '0) begin
        busy_o      <= 1'b1;
        idx_o       <= head_ptr_i;
        left        <= count_i;
        win_start_o <= win_start_i;
      end
    end else if (adv_i) begin
      idx_o <= idx_o + 1'b1;
      left  <= left - 1'b1;
      if (left == CW'(1)) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_hit_matcher.sv
module trig_hit_matcher
  import thm_pkg::*;
#(
  parameter int PAY_W   = 16,
  parameter int DEPTH   = 16,
  parameter int MAX_AGE = 240,
  parameter int LAT_W   = 8,
  parameter int UNC_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_trig_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [UNC_W-1:0] unc_i,
  input  logic [TS_W-1:0]  ts_now_i,
  input  logic             trig_i,
  input  logic             in_valid_i,
  input  logic [TS_W-1:0]  in_ts_i,
  input  logic [PAY_W-1:0] in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [TS_W-1:0]  out_ts_o,
  output logic [PAY_W-1:0] out_data_o,
  input  logic             out_ready_i
);
  localparam int ENT_W = TS_W + PAY_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;

  logic             act_mode;
  logic             push, pop, evict, aged, hit, adv, scan_start;
  logic             ring_empty, ring_full, scan_busy;
  logic [CW-1:0]    ring_cnt;
  logic [AW-1:0]    head_ptr, scan_idx;
  logic [ENT_W-1:0] head_ent, scan_ent;
  logic [TS_W-1:0]  head_ts, scan_ts, win_start_d, win_start_q;
  logic [PAY_W-1:0] head_pay, scan_pay;

  thm_ring #(.W(ENT_W), .DEPTH(DEPTH)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i ({in_ts_i, in_data_i}),
    .pop_i       (pop),
    .head_data_o (head_ent),
    .head_ptr_o  (head_ptr),
    .count_o     (ring_cnt),
    .rd_idx_i    (scan_idx),
    .rd_data_o   (scan_ent)
  );

  assign {head_ts, head_pay} = head_ent;
  assign {scan_ts, scan_pay} = scan_ent;
  assign ring_empty  = ring_cnt == '0;
  assign ring_full   = ring_cnt == CW'(DEPTH);
  assign win_start_d = ts_sub(ts_now_i, TS_W'(lat_i));
  assign scan_start  = trig_i && act_mode;

  thm_scan #(.AW(AW), .CW(CW), .TS_W(TS_W)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (scan_start),
    .head_ptr_i  (head_ptr),
    .count_i     (ring_cnt),
    .win_start_i (win_start_d),
    .adv_i       (adv),
    .busy_o      (scan_busy),
    .idx_o       (scan_idx),
    .win_start_o (win_start_q)
  );

  thm_window #(.UNC_W(UNC_W)) u_win (
    .ts_i    (scan_ts),
    .start_i (win_start_q),
    .unc_i   (unc_i),
    .hit_o   (hit)
  );

  // mode latches only between bursts so stored words keep their policy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         act_mode <= 1'b0;
    else if (ring_empty) act_mode <= mode_trig_i;
  end

  assign aged  = int'(ts_sub(ts_now_i, head_ts)) > MAX_AGE;
  assign evict = act_mode && !scan_busy && !ring_empty && aged;
  assign adv   = scan_busy && (!hit || out_ready_i);

  always_comb begin
    if (act_mode) begin
      out_valid_o = scan_busy && hit;
      out_ts_o    = scan_ts;
      out_data_o  = scan_pay;
    end else begin
      out_valid_o = !ring_empty;
      out_ts_o    = head_ts;
      out_data_o  = head_pay;
    end
  end

  assign pop        = evict || (!act_mode && out_valid_o && out_ready_i);
  assign in_ready_o = !ring_full && !scan_busy;
  assign push       = in_valid_i && in_ready_o;
endmodule

// File: rtl/thm_checker.sv
module thm_checker #(
  parameter int DEPTH = 16,
  parameter int PAY_W = 16,
  parameter int UNC_W = 3,
  parameter int TS_W  = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_i,
  input logic             out_valid_i,
  input logic             out_ready_i,
  input logic [TS_W-1:0]  out_ts_i,
  input logic [PAY_W-1:0] out_data_i,
  input logic             busy_i,
  input logic             act_mode_i,
  input logic             empty_i,
  input logic [CW-1:0]    count_i,
  input logic [TS_W-1:0]  ws_i,
  input logic [UNC_W-1:0] unc_i
);
  logic [TS_W-1:0] off;
  assign off = out_ts_i - ws_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_i) <= DEPTH); // R7
  AST_FULL_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_i) == DEPTH |-> !in_ready_i); // R7
  AST_SCAN_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !in_ready_i); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i && $stable(out_ts_i) && $stable(out_data_i)); // R9
  AST_MODE_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_mode_i) |-> $past(empty_i)); // R10
  AST_NO_SCAN_STREAMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_mode_i |-> !busy_i); // R2
  AST_OUT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode_i && out_valid_i |-> int'(off) <= int'(unc_i)); // R2
endmodule

bind trig_hit_matcher thm_checker #(
  .DEPTH(DEPTH), .PAY_W(PAY_W), .UNC_W(UNC_W), .TS_W(8)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_i  (in_ready_o),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_ts_i    (out_ts_o),
  .out_data_i  (out_data_o),
  .busy_i      (scan_busy),
  .act_mode_i  (act_mode),
  .empty_i     (ring_empty),
  .count_i     (ring_cnt),
  .ws_i        (win_start_q),
  .unc_i       (unc_i)
);

// File: tb/tb_trig_hit_matcher.sv
`timescale 1ns/1ps
module tb_trig_hit_matcher;
  logic        clk_i = 0, rst_ni = 0;
  logic        mode_trig_i = 0, trig_i = 0;
  logic [7:0]  lat_i = 0, ts_now_i = 0;
  logic [2:0]  unc_i = 0;
  logic        in_valid_i = 0, out_ready_i = 0;
  logic [7:0]  in_ts_i = 0;
  logic [15:0] in_data_i = 0;
  logic        in_ready_o, out_valid_o;
  logic [7:0]  out_ts_o;
  logic [15:0] out_data_o;

  int nvec = 0, nerr = 0, rdy_ctl = 0;
  string cur_req = "R11";
  logic [23:0] exp_q[$];
  logic [23:0] mdl[$];
  logic [7:0]  last_ts = 0;

  always #2 clk_i = ~clk_i;

  trig_hit_matcher dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk_i);
    out_ready_i = (rdy_ctl == 1) || (rdy_ctl == 2 && $urandom_range(0, 3) != 0);
    #1;
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) check(0, cur_req, {out_ts_o, out_data_o}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        check({out_ts_o, out_data_o} == e, cur_req, {out_ts_o, out_data_o}, e);
      end
    end
  end

  task automatic send(input logic [7:0] ts, input logic [15:0] d, input bit stream);
    @(negedge clk_i);
    in_valid_i = 1; in_ts_i = ts; in_data_i = d;
    #1;
    while (!in_ready_o) begin @(negedge clk_i); #1; end
    @(posedge clk_i); #1;
    in_valid_i = 0;
    last_ts = ts;
    if (stream) exp_q.push_back({ts, d}); else mdl.push_back({ts, d});
  endtask

  task automatic pulse();
    @(negedge clk_i); trig_i = 1;
    @(negedge clk_i); trig_i = 0;
  endtask

  task automatic fire();
    logic [7:0] ws, off;
    ws = ts_now_i - lat_i;
    foreach (mdl[i]) begin
      off = mdl[i][23:16] - ws;
      if (off <= 8'(unc_i)) exp_q.push_back(mdl[i]);
    end
    pulse();
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk_i); n++; end
    repeat (40) @(negedge clk_i);
    check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic flush();
    ts_now_i = last_ts + 8'd245;
    repeat (24) @(negedge clk_i);
    mdl.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    check(out_valid_o == 0, "R11", out_valid_o, 0);
    check(in_ready_o == 1, "R11", in_ready_o, 1);

    // R1 streaming order
    cur_req = "R1"; rdy_ctl = 2;
    for (int i = 0; i < 8; i++) send(8'(i * 37), 16'h1000 + 16'(i), 1);
    drain();

    // R9 backpressure hold
    cur_req = "R9"; rdy_ctl = 0;
    send(8'h11, 16'hA001, 1);
    send(8'h12, 16'hA002, 1);
    @(negedge clk_i); #1;
    check(out_valid_o && out_data_o == 16'hA001, "R9", out_data_o, 16'hA001);
    repeat (5) @(negedge clk_i);
    #1;
    check(out_valid_o && out_data_o == 16'hA001 && out_ts_o == 8'h11, "R9", out_data_o, 16'hA001);
    rdy_ctl = 1;
    drain();

    // R10 mode taken only when empty
    cur_req = "R10"; rdy_ctl = 0;
    send(8'h20, 16'hB001, 1);
    send(8'h21, 16'hB002, 1);
    send(8'h22, 16'hB003, 1);
    mode_trig_i = 1;
    repeat (3) @(negedge clk_i);
    rdy_ctl = 1;
    drain();
    ts_now_i = 8'h40;
    send(8'h40, 16'hB004, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i); #1;
      if (i == 9) check(out_valid_o == 0, "R10", out_valid_o, 0);
    end
    flush();

    // R3 inclusive edges
    cur_req = "R3"; rdy_ctl = 2;
    ts_now_i = 8'd240; lat_i = 8'd123; unc_i = 3'd6;
    send(8'd116, 16'hC116, 0);
    send(8'd117, 16'hC117, 0);
    send(8'd120, 16'hC120, 0);
    send(8'd123, 16'hC123, 0);
    send(8'd124, 16'hC124, 0);
    fire();
    drain();

    // R5 retained across scans
    cur_req = "R5";
    fire();
    drain();

    // R8 trigger during scan ignored, input stalled
    cur_req = "R8"; rdy_ctl = 0;
    fire();
    repeat (3) @(negedge clk_i);
    #1;
    check(in_ready_o == 0, "R8", in_ready_o, 0);
    pulse();
    rdy_ctl = 2;
    drain();
    flush();

    // R4 wraparound and zero width
    cur_req = "R4"; rdy_ctl = 2;
    ts_now_i = 8'd5; lat_i = 8'd10; unc_i = 3'd7;
    send(8'd250, 16'hD250, 0);
    send(8'd251, 16'hD251, 0);
    send(8'd0,   16'hD000, 0);
    send(8'd2,   16'hD002, 0);
    send(8'd3,   16'hD003, 0);
    fire();
    drain();
    lat_i = 8'd5; unc_i = 3'd0;
    fire();
    drain();
    flush();

    // R6 age eviction boundary
    cur_req = "R6";
    ts_now_i = 8'd100; lat_i = 8'd241; unc_i = 3'd1;
    send(8'd115, 16'hE115, 0);
    void'(mdl.pop_back());
    repeat (3) @(negedge clk_i);
    send(8'd116, 16'hE116, 0);
    repeat (3) @(negedge clk_i);
    fire();
    drain();
    flush();

    // R7 capacity
    cur_req = "R7"; rdy_ctl = 2;
    ts_now_i = 8'd60; lat_i = 8'd10; unc_i = 3'd7;
    for (int i = 0; i < 16; i++) send(8'd50 + 8'(i % 8), 16'hF000 + 16'(i), 0);
    @(negedge clk_i); #1;
    check(in_ready_o == 0, "R7", in_ready_o, 0);
    cur_req = "R2";
    fire();
    drain();
    flush();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule